// File: doc/BRIEF.md
# Test-Accelerated PHY Timer Base

This block is the common time base for the slow timers of an Ethernet transceiver. From a single clock it produces four periodic one-cycle tick strobes. One serves the 10 Mbit/s link-pulse timer, one the jabber timer, one the reset timer and one the autonegotiation counters. The block also contains a pulse stretcher that keeps an activity LED lit for a minimum time after each raw event. Every nominal period is a parameter given in clock cycles, so the same block fits any clock frequency.

For simulation and production test, a test-mode input together with a 2-bit rate select shortens all of these periods at once. The tick timers and the LED stretch time use the same rate code. The fastest code breaks autonegotiation, and a flag output marks it. The stretcher is switched on by either a pin or a register bit. A blink-enable input bypasses it, and the LED then follows the raw event directly.

Top module: `phy_timebase`

## Requirements
- R1: While `test_mode_i` is low, every tick strobe repeats with its nominal period (its `*_CYC` parameter, in clock cycles) for all four values of `rate_sel_i`.
- R2: While `test_mode_i` is high, every period, including the LED hold time, becomes max(1, nominal >> s). The shift s is 0 for `rate_sel_i`=00, 4 for 01, 6 for 10 and 8 for 11.
- R3: After reset is released, each tick strobe first goes high in the cycle that follows clock edge number P, where P is that timer's current period. Whenever P > 1, each strobe is high for exactly one cycle per period.
- R4: `aneg_unsup_o` is high exactly when `test_mode_i` is high and `rate_sel_i` is 11. The flag follows the inputs in the same cycle.
- R5: While stretching is active, `led_o` is high in any cycle where `led_evt_i` is high. After a one-cycle event it stays high for exactly P_led further cycles, P_led being the LED hold period of R1/R2, and then drops.
- R6: An event that arrives while a hold is running restarts the hold, so `led_o` stays high for P_led cycles after the newest event.
- R7: Stretching is active when `stretch_pin_i` OR `stretch_reg_i` is high and `blink_en_i` is low. Either source alone is enough.
- R8: While stretching is not active, `led_o` equals `led_evt_i` in the same cycle, and any hold in progress is discarded. An event seen before stretching was turned off does not light the LED after stretching is turned on again.
- R9: While `rst_n` is low, all tick strobes are low and no hold is pending. With `led_evt_i` low, `led_o` is therefore low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode_i | input | 1 | Enables timer acceleration |
| rate_sel_i | input | 2 | Acceleration code: 00 x1, 01 x16, 10 x64, 11 x256 |
| stretch_pin_i | input | 1 | LED stretch enable from a pin |
| stretch_reg_i | input | 1 | LED stretch enable from a control register |
| blink_en_i | input | 1 | Bypasses stretching when high |
| led_evt_i | input | 1 | Raw activity event |
| tick_link_o | output | 1 | Link-pulse timer strobe |
| tick_jabber_o | output | 1 | Jabber timer strobe |
| tick_reset_o | output | 1 | Reset timer strobe |
| tick_aneg_o | output | 1 | Autonegotiation counter strobe |
| led_o | output | 1 | Stretched activity LED |
| aneg_unsup_o | output | 1 | Marks the rate that breaks autonegotiation |

## Verification
A wrong rate decode or a wrong terminal count changes the spacing of the tick strobes. That shows up no later than the second strobe after reset, within two periods of the affected timer. A counter that fails to clear after it wraps shows up as a strobe held for two cycles, or as a first strobe that comes too early. Faults in the hold counter show up at `led_o` as a lit time that is too long or too short, measured in cycles from the last event. A hold left behind when stretching is turned off shows up one cycle after stretching is turned back on.

// File: rtl/phy_timebase_pkg.sv
package phy_timebase_pkg;

   typedef enum logic [1:0] {
      RATE_X1   = 2'd0,
      RATE_X16  = 2'd1,
      RATE_X64  = 2'd2,
      RATE_X256 = 2'd3
   } rate_e;

   localparam int unsigned NUM_TICKS = 4;
   localparam int unsigned TICK_LINK = 0;
   localparam int unsigned TICK_JAB  = 1;
   localparam int unsigned TICK_RST  = 2;
   localparam int unsigned TICK_ANEG = 3;

   // Right-shift applied to every terminal count for a given rate code.
   function automatic int unsigned rate_shift(rate_e r);
      case (r)
         RATE_X16:  return 4;
         RATE_X64:  return 6;
         RATE_X256: return 8;
         default:   return 0;
      endcase
   endfunction

   // Scaled period, never below one cycle.
   function automatic int unsigned scaled_cyc(int unsigned nominal, int unsigned sh);
      int unsigned v;
      v = nominal >> sh;
      return (v == 0) ? 1 : v;
   endfunction

   function automatic int unsigned cnt_width(int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/phy_rate_decode.sv
module phy_rate_decode
   import phy_timebase_pkg::*;
(
   input  logic       test_mode_i,
   input  logic [1:0] rate_sel_i,
   output rate_e      rate_o,
   output logic       aneg_unsup_o
);

   always_comb begin
      if (test_mode_i) begin
         rate_o = rate_e'(rate_sel_i);
      end else begin
         rate_o = RATE_X1;
      end
   end

   assign aneg_unsup_o = (rate_o == RATE_X256);

endmodule

// File: rtl/phy_tick_timer.sv
module phy_tick_timer
   import phy_timebase_pkg::*;
#(
   parameter int unsigned NOMINAL_CYC = 16
) (
   input  logic  clk,
   input  logic  rst_n,
   input  rate_e rate_i,
   output logic  tick_o
);

   localparam int unsigned CW = cnt_width(NOMINAL_CYC);
   localparam int unsigned LAST_X1   = scaled_cyc(NOMINAL_CYC, 0) - 1;
   localparam int unsigned LAST_X16  = scaled_cyc(NOMINAL_CYC, 4) - 1;
   localparam int unsigned LAST_X64  = scaled_cyc(NOMINAL_CYC, 6) - 1;
   localparam int unsigned LAST_X256 = scaled_cyc(NOMINAL_CYC, 8) - 1;

   if (NOMINAL_CYC < 1) begin : g_bad_cyc
      $error("phy_tick_timer: NOMINAL_CYC must be at least 1");
   end
   if (CW > 32) begin : g_bad_width
      $error("phy_tick_timer: counter wider than 32 bits");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last;
   logic          tick_q;

   always_comb begin
      case (rate_i)
         RATE_X16:  last = CW'(LAST_X16);
         RATE_X64:  last = CW'(LAST_X64);
         RATE_X256: last = CW'(LAST_X256);
         default:   last = CW'(LAST_X1);
      endcase
   end

   // A count left above a freshly shortened limit wraps at once.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else if (cnt_q >= last) begin
         cnt_q  <= '0;
         tick_q <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         tick_q <= 1'b0;
      end
   end

   assign tick_o = tick_q;

endmodule

// File: rtl/phy_led_stretch.sv
module phy_led_stretch
   import phy_timebase_pkg::*;
#(
   parameter int unsigned HOLD_CYC = 16
) (
   input  logic  clk,
   input  logic  rst_n,
   input  rate_e rate_i,
   input  logic  enable_i,
   input  logic  evt_i,
   output logic  led_o
);

   localparam int unsigned CW = cnt_width(HOLD_CYC);
   localparam int unsigned H_X1   = scaled_cyc(HOLD_CYC, 0);
   localparam int unsigned H_X16  = scaled_cyc(HOLD_CYC, 4);
   localparam int unsigned H_X64  = scaled_cyc(HOLD_CYC, 6);
   localparam int unsigned H_X256 = scaled_cyc(HOLD_CYC, 8);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("phy_led_stretch: HOLD_CYC must be at least 1");
   end
   if (CW > 32) begin : g_bad_width
      $error("phy_led_stretch: hold counter wider than 32 bits");
   end

   logic [CW-1:0] hold_q;
   logic [CW-1:0] load;

   always_comb begin
      case (rate_i)
         RATE_X16:  load = CW'(H_X16);
         RATE_X64:  load = CW'(H_X64);
         RATE_X256: load = CW'(H_X256);
         default:   load = CW'(H_X1);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !enable_i) begin
         hold_q <= '0;
      end else if (evt_i) begin
         hold_q <= load;
      end else if (hold_q != '0) begin
         hold_q <= hold_q - 1'b1;
      end
   end

   assign led_o = evt_i | (enable_i & (hold_q != '0));

endmodule

// File: rtl/phy_timebase.sv
module phy_timebase
   import phy_timebase_pkg::*;
#(
   parameter int unsigned LINK_CYC  = 400_000,
   parameter int unsigned JAB_CYC   = 1_250_000,
   parameter int unsigned RST_CYC   = 250_000,
   parameter int unsigned ANEG_CYC  = 200_000,
   parameter int unsigned LED_CYC   = 1_050_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       test_mode_i,
   input  logic [1:0] rate_sel_i,
   input  logic       stretch_pin_i,
   input  logic       stretch_reg_i,
   input  logic       blink_en_i,
   input  logic       led_evt_i,
   output logic       tick_link_o,
   output logic       tick_jabber_o,
   output logic       tick_reset_o,
   output logic       tick_aneg_o,
   output logic       led_o,
   output logic       aneg_unsup_o
);

   rate_e                rate_w;
   logic                 stretch_en_w;
   logic [NUM_TICKS-1:0] tick_w;

   phy_rate_decode u_dec (
      .test_mode_i  (test_mode_i),
      .rate_sel_i   (rate_sel_i),
      .rate_o       (rate_w),
      .aneg_unsup_o (aneg_unsup_o)
   );

   for (genvar g = 0; g < NUM_TICKS; g++) begin : g_tick
      localparam int unsigned CYC =
         (g == TICK_LINK) ? LINK_CYC :
         (g == TICK_JAB)  ? JAB_CYC  :
         (g == TICK_RST)  ? RST_CYC  : ANEG_CYC;
      phy_tick_timer #(.NOMINAL_CYC(CYC)) u_tmr (
         .clk    (clk),
         .rst_n  (rst_n),
         .rate_i (rate_w),
         .tick_o (tick_w[g])
      );
   end

   assign tick_link_o   = tick_w[TICK_LINK];
   assign tick_jabber_o = tick_w[TICK_JAB];
   assign tick_reset_o  = tick_w[TICK_RST];
   assign tick_aneg_o   = tick_w[TICK_ANEG];

   assign stretch_en_w = (stretch_pin_i | stretch_reg_i) & ~blink_en_i;

   phy_led_stretch #(.HOLD_CYC(LED_CYC)) u_led (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_i   (rate_w),
      .enable_i (stretch_en_w),
      .evt_i    (led_evt_i),
      .led_o    (led_o)
   );

endmodule

// File: rtl/phy_timebase_chk.sv
module phy_timebase_chk
   import phy_timebase_pkg::*;
#(
   parameter int unsigned LINK_CYC = 16,
   parameter int unsigned JAB_CYC  = 16
) (
   input logic  clk,
   input logic  rst_n,
   input logic  test_mode_i,
   input rate_e rate,
   input logic  stretch_on,
   input logic  led_evt_i,
   input logic  led_o,
   input logic  tick_link_o,
   input logic  tick_jabber_o,
   input logic  aneg_unsup_o
);

   AST_NORMAL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      !test_mode_i |-> (rate == RATE_X1)); // R1

   AST_UNSUP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      aneg_unsup_o |-> (test_mode_i && rate == RATE_X256)); // R4

   AST_UNSUP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rate != RATE_X256) |-> !aneg_unsup_o); // R4

   AST_LINK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_link_o && scaled_cyc(LINK_CYC, rate_shift(rate)) > 1) |=> !tick_link_o); // R3

   AST_JAB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_jabber_o && scaled_cyc(JAB_CYC, rate_shift(rate)) > 1) |=> !tick_jabber_o); // R3

   AST_LED_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      led_evt_i |-> led_o); // R5

   AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(stretch_on) && $past(led_evt_i) && stretch_on) |-> led_o); // R5

   AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      !stretch_on |-> (led_o == led_evt_i)); // R8

endmodule

bind phy_timebase phy_timebase_chk #(
   .LINK_CYC (LINK_CYC),
   .JAB_CYC  (JAB_CYC)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .test_mode_i   (test_mode_i),
   .rate          (rate_w),
   .stretch_on    (stretch_en_w),
   .led_evt_i     (led_evt_i),
   .led_o         (led_o),
   .tick_link_o   (tick_link_o),
   .tick_jabber_o (tick_jabber_o),
   .aneg_unsup_o  (aneg_unsup_o)
);

// File: tb/sim_phy_timebase.sv
`timescale 1ns/1ps
module sim_phy_timebase;

   localparam int unsigned C_LINK = 600;
   localparam int unsigned C_JAB  = 1100;
   localparam int unsigned C_RST  = 200;
   localparam int unsigned C_ANEG = 900;
   localparam int unsigned C_LED  = 300;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       test_mode = 1'b0;
   logic [1:0] rate_sel = 2'b00;
   logic       s_pin = 1'b0;
   logic       s_reg = 1'b0;
   logic       blink = 1'b0;
   logic       evt = 1'b0;
   logic       t_link, t_jab, t_rst, t_aneg, led, unsup;
   logic [3:0] ticks;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   phy_timebase #(
      .LINK_CYC (C_LINK),
      .JAB_CYC  (C_JAB),
      .RST_CYC  (C_RST),
      .ANEG_CYC (C_ANEG),
      .LED_CYC  (C_LED)
   ) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .test_mode_i   (test_mode),
      .rate_sel_i    (rate_sel),
      .stretch_pin_i (s_pin),
      .stretch_reg_i (s_reg),
      .blink_en_i    (blink),
      .led_evt_i     (evt),
      .tick_link_o   (t_link),
      .tick_jabber_o (t_jab),
      .tick_reset_o  (t_rst),
      .tick_aneg_o   (t_aneg),
      .led_o         (led),
      .aneg_unsup_o  (unsup)
   );

   assign ticks = {t_aneg, t_rst, t_jab, t_link};

   function automatic int exp_period(int unsigned nom, logic t, logic [1:0] s);
      int unsigned sh;
      int unsigned v;
      sh = !t ? 0 : (s == 2'd0) ? 0 : (s == 2'd1) ? 4 : (s == 2'd2) ? 6 : 8;
      v = nom >> sh;
      return (v == 0) ? 1 : int'(v);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic apply_reset(input logic t, input logic [1:0] s);
      @(negedge clk);
      rst_n = 1'b0;
      test_mode = t;
      rate_sel = s;
      evt = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check(ticks == 4'b0 && led == 1'b0, "R9 reset outputs", {ticks, led}, 0);
      rst_n = 1'b1;
   endtask

   task automatic run_timers(input logic t, input logic [1:0] s);
      int p[4];
      int first[4];
      int second[4];
      bit prev[4];
      bit dbl[4];
      int lim;
      p[0] = exp_period(C_LINK, t, s);
      p[1] = exp_period(C_JAB, t, s);
      p[2] = exp_period(C_RST, t, s);
      p[3] = exp_period(C_ANEG, t, s);
      lim = 0;
      for (int i = 0; i < 4; i++) begin
         first[i] = 0; second[i] = 0; prev[i] = 0; dbl[i] = 0;
         if (p[i] > lim) lim = p[i];
      end
      lim = 2 * lim + 3;
      apply_reset(t, s);
      for (int k = 1; k <= lim; k++) begin
         @(negedge clk);
         for (int i = 0; i < 4; i++) begin
            if (ticks[i]) begin
               if (first[i] == 0) first[i] = k;
               else if (second[i] == 0) second[i] = k;
               if (prev[i] && p[i] > 1) dbl[i] = 1;
            end
            prev[i] = ticks[i];
         end
      end
      for (int i = 0; i < 4; i++) begin
         check(first[i] == p[i], "R3 first tick edge", first[i], p[i]);
         if (t)
            check(second[i] - first[i] == p[i], "R2 scaled period", second[i] - first[i], p[i]);
         else
            check(second[i] - first[i] == p[i], "R1 nominal period", second[i] - first[i], p[i]);
         check(!dbl[i], "R3 single-cycle strobe", dbl[i], 0);
      end
   endtask

   // Counts lit cycles after a one-cycle event; returns -1 if the event cycle was dark.
   task automatic led_pulse(output int lit);
      bit ev_ok;
      @(negedge clk);
      evt = 1'b1;
      #1;
      ev_ok = led;
      @(negedge clk);
      evt = 1'b0;
      #1;
      lit = 0;
      while (led && lit < C_LED + 5) begin
         lit++;
         @(negedge clk);
         #1;
      end
      if (!ev_ok) lit = -1;
   endtask

   task automatic led_case(input logic t, input logic [1:0] s, input logic pin,
                           input logic rg, input logic bl, input int exp, input string req);
      int lit;
      s_pin = pin; s_reg = rg; blink = bl;
      apply_reset(t, s);
      led_pulse(lit);
      check(lit == exp, req, lit, exp);
   endtask

   initial begin
      int lit;
      bit ok;
      int p;

      // R4: flag over every input combination
      for (int t = 0; t < 2; t++) begin
         for (int s = 0; s < 4; s++) begin
            test_mode = t[0];
            rate_sel = s[1:0];
            #1;
            check(unsup == (t == 1 && s == 3), "R4 unsupported flag", unsup, (t == 1 && s == 3));
         end
      end

      // R1, R2, R3: period sweep over every rate code, test mode off and on
      for (int t = 0; t < 2; t++) begin
         for (int s = 0; s < 4; s++) begin
            run_timers(t[0], s[1:0]);
         end
      end

      // R5, R2: hold length across rates
      for (int s = 0; s < 4; s++) begin
         led_case(1'b1, s[1:0], 1'b1, 1'b0, 1'b0, exp_period(C_LED, 1'b1, s[1:0]),
                  "R5 hold length scaled");
      end
      led_case(1'b0, 2'b11, 1'b1, 1'b0, 1'b0, C_LED, "R5 hold length nominal");

      // R7: either source enables; neither does not
      led_case(1'b1, 2'b01, 1'b0, 1'b1, 1'b0, exp_period(C_LED, 1'b1, 2'b01), "R7 register enable");
      led_case(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 0, "R7 no enable source");

      // R8: blink bypasses stretching
      led_case(1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 0, "R8 blink bypass");

      // R6: retrigger restarts the hold
      p = exp_period(C_LED, 1'b1, 2'b01);
      s_pin = 1'b1; s_reg = 1'b0; blink = 1'b0;
      apply_reset(1'b1, 2'b01);
      @(negedge clk);
      evt = 1'b1;
      @(negedge clk);
      evt = 1'b0;
      ok = 1;
      for (int i = 0; i < 9; i++) begin
         #1;
         if (!led) ok = 0;
         @(negedge clk);
      end
      check(ok, "R6 lit between events", ok, 1);
      led_pulse(lit);
      check(lit == p, "R6 hold restarted", lit, p);

      // R8: pending hold discarded when stretching turns off
      apply_reset(1'b1, 2'b01);
      @(negedge clk);
      evt = 1'b1;
      @(negedge clk);
      evt = 1'b0;
      repeat (3) @(negedge clk);
      blink = 1'b1;
      #1;
      check(led == 1'b0, "R8 bypass follows event", led, 0);
      @(negedge clk);
      blink = 1'b0;
      #1;
      check(led == 1'b0, "R8 hold discarded", led, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule